// File: doc/BRIEF.md
# Subword-Parallel Multiply-Accumulate Unit

This block is a pipelined integer multiplier whose 32-bit operand path is split at run time into independent lanes. A two-bit mode input picks four byte lanes (four 8x8 products), two halfword lanes (two 16x16 products), or a single wide 32x16 product. The wide product is built by running the low and high halves of operand A through the same 16x16 lane hardware on two consecutive cycles and merging the two partial results.

Two separate sign inputs give the signedness of operand A and of operand B, so any mix of signed and unsigned products is available in every mode. When the accumulate input is set in a byte or halfword mode, each lane adds its product into its own wrapping accumulator slot and returns the new sum. A synchronous clear input zeroes the accumulators. Results come out on a 64-bit bus with a valid flag, at a fixed distance from the accepting clock edge.

Top module: `smac_unit`

## Requirements
- R1: Mode code 00 is byte mode. result[16k+15:16k] is the 16-bit product of opa byte k and opb byte k, for k = 0..3. Each lane is independent, so no carry or sign bit crosses between lanes.
- R2: Mode code 01 is halfword mode. result[32k+31:32k] is the 32-bit product of opa halfword k and opb halfword k, for k = 0..1, with no effect across the lane boundary. Code 11 behaves exactly like code 01.
- R3: Mode code 10 is wide mode. result[47:0] is the 48-bit product of the full 32-bit opa and opb[15:0]. result[63:48] is zero, and opb[31:16] has no effect.
- R4: a_signed set makes every A lane two's complement; clear makes it unsigned. b_signed does the same for B. The two are independent. In wide mode a_signed applies to the whole 32-bit opa.
- R5: An operation is accepted on a rising edge where in_valid and in_ready are both high. Its result and out_valid appear after the second rising edge that follows the accepting one. Results leave in issue order, and result holds its value while out_valid is low.
- R6: In byte and halfword modes in_ready stays high, so a new operation is accepted on every edge.
- R7: After a wide-mode operation is accepted, in_ready is low for exactly the next cycle, so the next operation is accepted one edge later.
- R8: With acc_en set in byte mode, each 16-bit accumulator slot k (acc bits [16k+15:16k]) adds lane k's product modulo 2^16. In halfword mode each 32-bit slot adds modulo 2^32. The result is the new accumulator value.
- R9: With acc_en clear, the result is the plain product and the accumulators keep their value.
- R10: In wide mode acc_en is ignored: the result is the product and the accumulators keep their value.
- R11: acc_clr zeroes all accumulators on the next rising edge, so the next accumulating operation returns its own product.
- R12: While rst_n is low, out_valid is 0, in_ready is 1, result is 0 and the accumulators are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented on the inputs |
| in_ready | output | 1 | Block can accept an operation on this edge |
| mode | input | 2 | 00 byte, 01 halfword, 10 wide, 11 same as halfword |
| a_signed | input | 1 | Operand A lanes are two's complement |
| b_signed | input | 1 | Operand B lanes are two's complement |
| acc_en | input | 1 | Add products into the lane accumulators |
| acc_clr | input | 1 | Synchronous clear of the accumulators |
| opa | input | 32 | Packed operand A |
| opb | input | 32 | Packed operand B |
| out_valid | output | 1 | result carries a finished operation |
| result | output | 64 | Packed lane products or accumulator sums |

## Verification
The timing properties assume that reset never lands between accepting an operation and its result. They also assume that in_valid counts only together with in_ready, so a caller must hold an operation until it is taken. The accumulator properties assume that acc_clr is a plain level input with no relation to the operation in flight. The bench keeps to these assumptions: it resets only at the start, it holds each operation until in_ready is high, and it pulses acc_clr only after the pipeline has drained. Its reference model can then apply each clear between whole operations.

// File: rtl/smac_pkg.sv
// Shared definitions for the subword multiply-accumulate unit.
// Assumes byte lanes of LANE_B bits and four byte lanes per operand.
package smac_pkg;
    localparam int LANE_B = 8;

    typedef enum logic [1:0] {
        MD_BYTE = 2'b00,
        MD_HALF = 2'b01,
        MD_WIDE = 2'b10,
        MD_ALT  = 2'b11
    } mode_e;
endpackage

// File: rtl/smac_tile.sv
// One signed tile multiplier of the shared array.
// Assumes the caller has already placed the sign or zero extension bit in the top bit of each input.
module smac_tile #(
    parameter int W = 9
) (
    input  logic signed [W-1:0]   x,
    input  logic signed [W-1:0]   y,
    output logic signed [2*W-1:0] p
);
    // Plain signed product of the extended inputs.
    assign p = x * y;
endmodule

// File: rtl/smac_lane.sv
// One 2*BW-bit lane of the shared multiplier array, built from four tiles.
// When split is set, the lane gives two independent BW x BW products.
// When split is clear, it gives one exact (2*BW) x (2*BW) product of 4*BW+1 bits.
// Assumes the sign selects apply to the top byte of each lane part.
module smac_lane #(
    parameter int BW = 8
) (
    input  logic [2*BW-1:0] a,
    input  logic [2*BW-1:0] b,
    input  logic            a_sgn,
    input  logic            b_sgn,
    input  logic            split,
    output logic [4*BW-1:0] p_split,
    output logic [4*BW:0]   p_full
);
    localparam int TW = BW + 1;
    localparam int SW = 4 * BW + 1;

    logic signed [TW-1:0]   ax [2];
    logic signed [TW-1:0]   bx [2];
    logic signed [2*TW-1:0] pp [4];
    logic signed [SW-1:0]   sum_s;

    // Extension bits: a low byte is signed only when it forms a lane of its own.
    always_comb begin
        ax[0] = {split & a_sgn & a[BW-1], a[BW-1:0]};
        ax[1] = {a_sgn & a[2*BW-1], a[2*BW-1:BW]};
        bx[0] = {split & b_sgn & b[BW-1], b[BW-1:0]};
        bx[1] = {b_sgn & b[2*BW-1], b[2*BW-1:BW]};
    end

    for (genvar i = 0; i < 2; i++) begin : g_row
        for (genvar j = 0; j < 2; j++) begin : g_col
            smac_tile #(.W(TW)) u_tile (
                .x (ax[i]),
                .y (bx[j]),
                .p (pp[2*i+j])
            );
        end
    end

    // Merge the four tile products into the full lane product.
    always_comb begin
        sum_s = SW'(pp[0]) + (SW'(pp[1]) <<< BW) + (SW'(pp[2]) <<< BW) + (SW'(pp[3]) <<< (2*BW));
    end

    assign p_full  = sum_s;
    assign p_split = {pp[3][2*BW-1:0], pp[0][2*BW-1:0]};
endmodule

// File: rtl/smac_unit.sv
// Subword-parallel multiply-accumulate unit, top level.
// Stage 1 registers the operation. Stage 2 holds the lane products, or the low
// partial product in wide mode. Stage 3 merges, accumulates and drives the result.
// Wide mode reuses lane 0 for the high partial product while the operation sits in
// stage 2, so input acceptance pauses for one cycle.
// Assumes reset is not applied while an operation is in flight.
module smac_unit
    import smac_pkg::*;
#(
    parameter int B = LANE_B
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [1:0]     mode,
    input  logic           a_signed,
    input  logic           b_signed,
    input  logic           acc_en,
    input  logic           acc_clr,
    input  logic [4*B-1:0] opa,
    input  logic [4*B-1:0] opb,
    output logic           out_valid,
    output logic [8*B-1:0] result
);
    localparam int H  = 2 * B;
    localparam int W  = 4 * B;
    localparam int PW = 6 * B;
    localparam int RW = 8 * B;

    // Stage 1 state
    logic         s1_v, s1_as, s1_bs, s1_acc;
    mode_e        s1_mode;
    logic [W-1:0] s1_a, s1_b;
    // Stage 2 state
    logic         s2_v, s2_as, s2_bs, s2_acc;
    mode_e        s2_mode;
    logic [H-1:0] s2_ahi, s2_blo;
    logic [W-1:0] s2_l0s, s2_l1s;
    logic [W:0]   s2_l0f;
    logic [W-1:0] s2_l1f;
    // Lane interfaces
    logic [H-1:0] l0_a, l0_b;
    logic         l0_as, l0_bs, l0_split, l1_split, pass2;
    logic [W-1:0] l0_ps, l1_ps;
    logic [W:0]   l0_pf, l1_pf;
    // Stage 3 state
    logic [RW-1:0]        acc_q, prod, acc_next;
    logic [RW-1:0]        sum_b, sum_h;
    logic signed [PW-1:0] wide_sum;
    logic                 do_acc;

    assign in_ready = !(s1_v && s1_mode == MD_WIDE);

    // Stage 1: capture an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s1_mode <= MD_BYTE; s1_as <= 1'b0; s1_bs <= 1'b0;
            s1_acc <= 1'b0; s1_a <= '0; s1_b <= '0;
        end else begin
            s1_v <= in_valid && in_ready;
            if (in_valid && in_ready) begin
                s1_mode <= mode_e'(mode);
                s1_as   <= a_signed;
                s1_bs   <= b_signed;
                s1_acc  <= acc_en;
                s1_a    <= opa;
                s1_b    <= opb;
            end
        end
    end

    // Lane 0 input select: the wide high pass uses stage 2 operands, otherwise stage 1.
    always_comb begin
        pass2    = s2_v && s2_mode == MD_WIDE;
        l0_a     = pass2 ? s2_ahi : s1_a[H-1:0];
        l0_b     = pass2 ? s2_blo : s1_b[H-1:0];
        l0_as    = pass2 ? s2_as : (s1_as && s1_mode != MD_WIDE);
        l0_bs    = pass2 ? s2_bs : s1_bs;
        l0_split = !pass2 && s1_mode == MD_BYTE;
        l1_split = s1_mode == MD_BYTE;
    end

    smac_lane #(.BW(B)) u_lane0 (
        .a (l0_a), .b (l0_b), .a_sgn (l0_as), .b_sgn (l0_bs),
        .split (l0_split), .p_split (l0_ps), .p_full (l0_pf)
    );

    smac_lane #(.BW(B)) u_lane1 (
        .a (s1_a[W-1:H]), .b (s1_b[W-1:H]), .a_sgn (s1_as), .b_sgn (s1_bs),
        .split (l1_split), .p_split (l1_ps), .p_full (l1_pf)
    );

    // Stage 2: register lane products and the operands still needed by the wide pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v <= 1'b0; s2_mode <= MD_BYTE; s2_as <= 1'b0; s2_bs <= 1'b0;
            s2_acc <= 1'b0; s2_ahi <= '0; s2_blo <= '0;
            s2_l0s <= '0; s2_l1s <= '0; s2_l0f <= '0; s2_l1f <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_mode <= s1_mode;
                s2_as   <= s1_as;
                s2_bs   <= s1_bs;
                s2_acc  <= s1_acc;
                s2_ahi  <= s1_a[W-1:H];
                s2_blo  <= s1_b[H-1:0];
                s2_l0s  <= l0_ps;
                s2_l1s  <= l1_ps;
                s2_l0f  <= l0_pf;
                s2_l1f  <= l1_pf[W-1:0];
            end
        end
    end

    // Wide merge: high partial shifted by one halfword plus the stored low partial.
    always_comb begin
        wide_sum = (PW'($signed(l0_pf)) <<< H) + PW'($signed(s2_l0f));
    end

    // Product assembly chosen by the mode travelling with the data.
    always_comb begin
        case (s2_mode)
            MD_BYTE: prod = {s2_l1s, s2_l0s};
            MD_WIDE: prod = {{(RW-PW){1'b0}}, wide_sum};
            default: prod = {s2_l1f, s2_l0f[W-1:0]};
        endcase
    end

    for (genvar k = 0; k < 4; k++) begin : g_bsum
        assign sum_b[k*H +: H] = acc_q[k*H +: H] + prod[k*H +: H];
    end
    for (genvar k = 0; k < 2; k++) begin : g_hsum
        assign sum_h[k*W +: W] = acc_q[k*W +: W] + prod[k*W +: W];
    end

    assign acc_next = (s2_mode == MD_BYTE) ? sum_b : sum_h;
    assign do_acc   = s2_v && s2_acc && s2_mode != MD_WIDE;

    // Stage 3: output register and lane accumulators. A clear wins over an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            acc_q     <= '0;
        end else begin
            out_valid <= s2_v;
            if (s2_v) result <= do_acc ? acc_next : prod;
            if (acc_clr)     acc_q <= '0;
            else if (do_acc) acc_q <= acc_next;
        end
    end

    // R5: a result only appears where an operation was accepted three edges earlier.
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready, 3));

    // R5: result holds while nothing completes.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_v |=> $stable(result));

    // R7: a wide accept is followed by one cycle without acceptance.
    p_wide_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && mode == 2'b10) |=> !in_ready);

    // R9: a non-accumulating operation leaves the accumulators alone.
    p_plain_keeps_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && !s2_acc && !acc_clr) |=> $stable(acc_q));

    // R10: wide mode never updates the accumulators.
    p_wide_keeps_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && s2_mode == MD_WIDE && !acc_clr) |=> $stable(acc_q));

    // R11: a clear leaves all accumulator slots at zero.
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_q == '0));
endmodule

// File: tb/sim_smac_unit.sv
// Directed bench for smac_unit with an in-order reference model.
module sim_smac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  mode = 2'b00;
    logic        a_signed = 1'b0, b_signed = 1'b0, acc_en = 1'b0, acc_clr = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [63:0] result;

    always #10 clk = ~clk;

    smac_unit u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .mode (mode), .a_signed (a_signed), .b_signed (b_signed), .acc_en (acc_en),
        .acc_clr (acc_clr), .opa (opa), .opb (opb), .out_valid (out_valid), .result (result)
    );

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [63:0] acc_m = '0;
    logic [63:0] last_res = '0;
    logic [63:0] exp_q[$];
    int          edge_q[$];
    string       tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint sx(input logic [31:0] v, input int w, input bit s);
        longint r;
        r = longint'(v) & ((longint'(1) <<< w) - 1);
        if (s && v[w-1]) r = r - (longint'(1) <<< w);
        return r;
    endfunction

    // Reference model, applied in issue order; updates the accumulator model.
    function automatic logic [63:0] model(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b,
                                          input bit sa, input bit sb, input bit ac);
        logic [63:0] p;
        longint      t;
        p = '0;
        if (m == 2'b00) begin
            for (int k = 0; k < 4; k++) begin
                t = sx(a >> (8*k), 8, sa) * sx(b >> (8*k), 8, sb);
                p[16*k +: 16] = t[15:0];
            end
        end else if (m == 2'b10) begin
            t = sx(a, 32, sa) * sx({16'b0, b[15:0]}, 16, sb);
            p = {16'b0, t[47:0]};
        end else begin
            for (int k = 0; k < 2; k++) begin
                t = sx(a >> (16*k), 16, sa) * sx(b >> (16*k), 16, sb);
                p[32*k +: 32] = t[31:0];
            end
        end
        if (ac && m != 2'b10) begin
            if (m == 2'b00) for (int k = 0; k < 4; k++) acc_m[16*k +: 16] = acc_m[16*k +: 16] + p[16*k +: 16];
            else            for (int k = 0; k < 2; k++) acc_m[32*k +: 32] = acc_m[32*k +: 32] + p[32*k +: 32];
            p = acc_m;
        end
        return p;
    endfunction

    // Compares each completed result with the model and checks its latency and hold.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected out_valid", result, '0);
                end else begin
                    logic [63:0] e;
                    int          ed;
                    string       tg;
                    e  = exp_q.pop_front();
                    ed = edge_q.pop_front();
                    tg = tag_q.pop_front();
                    check(result === e, tg, result, e);
                    check(cyc == ed + 2, "R5 latency", 64'(cyc - ed), 64'd2);
                end
            end else if (result !== last_res) begin
                check(1'b0, "R5 hold while idle", result, last_res);
            end
            last_res = result;
        end
    end

    task automatic issue(input logic [1:0] m, input logic [31:0] a, input logic [31:0] b,
                         input bit sa, input bit sb, input bit ac, input string tag, output bit rdy0);
        logic [63:0] e;
        e = model(m, a, b, sa, sb, ac);
        mode = m; opa = a; opb = b; a_signed = sa; b_signed = sb; acc_en = ac;
        in_valid = 1'b1;
        rdy0 = in_ready;
        while (!in_ready) @(negedge clk);
        exp_q.push_back(e);
        edge_q.push_back(cyc + 1);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic drain();
        in_valid = 1'b0;
        acc_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic clear_acc();
        drain();
        acc_clr = 1'b1;
        @(negedge clk);
        acc_clr = 1'b0;
        acc_m = '0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R12 out_valid in reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R12 in_ready in reset", 64'(in_ready), 64'd1);
        check(result == '0, "R12 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_byte();
        bit r;
        for (int s = 0; s < 4; s++) begin
            issue(2'b00, 32'h80FF7F01, 32'h80FFFF02, s[0], s[1], 1'b0, "R1 R4 byte lanes signs", r);
            issue(2'b00, 32'hFF80FF7F, 32'hFFFF807F, s[0], s[1], 1'b0, "R1 R4 byte lane isolation", r);
        end
        drain();
    endtask

    task automatic t_half();
        bit r;
        for (int s = 0; s < 4; s++) begin
            issue(2'b01, 32'h8000FFFF, 32'hFFFF8000, s[0], s[1], 1'b0, "R2 R4 halfword signs", r);
        end
        issue(2'b11, 32'h12345678, 32'h9ABCDEF0, 1'b1, 1'b0, 1'b0, "R2 code 11 as halfword", r);
        drain();
    endtask

    task automatic t_wide();
        bit r;
        for (int s = 0; s < 4; s++) begin
            issue(2'b10, 32'hFFFFFFFF, 32'hABCDFFFF, s[0], s[1], 1'b0, "R3 R4 wide signs", r);
            check(in_ready == 1'b0, "R7 ready low after wide", 64'(in_ready), 64'd0);
        end
        issue(2'b10, 32'h80000000, 32'h55557FFF, 1'b1, 1'b1, 1'b0, "R3 wide extreme", r);
        issue(2'b00, 32'h01020304, 32'h05060708, 1'b0, 1'b0, 1'b0, "R7 op after wide", r);
        check(r == 1'b0, "R7 op after wide waited", 64'(r), 64'd0);
        drain();
    endtask

    task automatic t_stream();
        bit r;
        for (int i = 0; i < 12; i++) begin
            issue(i[0] ? 2'b01 : 2'b00, 32'h9E3779B9 * (i + 1), 32'h7F4A7C15 ^ (i * 32'h01010101),
                  i[1], i[2], 1'b0, "R5 R6 mixed stream", r);
            check(r == 1'b1, "R6 ready in stream", 64'(r), 64'd1);
        end
        drain();
    endtask

    task automatic t_acc();
        bit r;
        clear_acc();
        issue(2'b00, 32'hFFFF0102, 32'hFFFF0304, 1'b0, 1'b0, 1'b1, "R8 byte accumulate", r);
        issue(2'b00, 32'hFFFF0102, 32'hFFFF0304, 1'b0, 1'b0, 1'b1, "R8 byte wrap", r);
        issue(2'b00, 32'h80808080, 32'h7F7F7F7F, 1'b1, 1'b1, 1'b0, "R9 plain product", r);
        issue(2'b00, 32'h01010101, 32'h01010101, 1'b0, 1'b0, 1'b1, "R9 acc kept after plain", r);
        issue(2'b10, 32'h12345678, 32'h00001111, 1'b0, 1'b0, 1'b1, "R10 wide ignores acc_en", r);
        issue(2'b00, 32'h01010101, 32'h01010101, 1'b0, 1'b0, 1'b1, "R10 acc kept after wide", r);
        clear_acc();
        issue(2'b01, 32'hFFFF8000, 32'hFFFF8000, 1'b0, 1'b1, 1'b1, "R11 first sum after clear", r);
        issue(2'b01, 32'hFFFF8000, 32'hFFFF8000, 1'b0, 1'b1, 1'b1, "R8 halfword accumulate", r);
        clear_acc();
        issue(2'b00, 32'h00000003, 32'h00000005, 1'b0, 1'b0, 1'b1, "R11 sum equals product", r);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_byte();
        t_half();
        t_wide();
        t_stream();
        t_acc();
        check(exp_q.size() == 0, "R5 all results returned", 64'(exp_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule